// File: doc/BRIEF.md
# DDR Memory Power-Up Initialization Sequencer

This block is the controller-side state machine that takes a double-data-rate memory from power-on to normal operation. After reset it holds the power-down pin low and keeps the command bus idle until the clock has been stable long enough. It then raises power-down together with a NOP and walks through a fixed command series: close all banks, an extended mode write that turns the DLL on, and a mode write that resets the DLL. After that it issues the refresh pair and the final mode write, in an order picked by a configuration input. Every wait period is a cycle count computed from a clock-period parameter.

An optional test window can come before the regular series. When `testEn` is high at reset release, the sequencer first waits a minimum stable-power period. It then raises `testWindow` and holds it until the test logic pulses `testDone`. Only after that does the 200 µs clock-stable wait start. When the last command has gone out, `done` rises and the bus stays idle until the next reset.

Top module: `ddr_init_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, `pd`, `done` and `testWindow` are low and the bus carries NOP (`{csN,rasN,casN,weN}` = 0111).
- R2: `pd` stays low and the bus stays at NOP for at least the stable-clock count (200 µs in cycles, 25000 at the default 8000 ps period). This count is taken from reset release, or from the `testDone` pulse when the test window was used. `pd` then rises in the same cycle as a NOP and stays high until reset.
- R3: The first command after the power-down release is close-all-banks: pins 0010 with `addr[10]` = 1.
- R4: The next command is an extended mode write: pins 0000, `bank` = 1, `addr` = EXT_VALUE with bit 0 (DLL disable) forced to 0. It comes at least the row-precharge count (2 cycles by default) after close-all.
- R5: The next command is a mode write with the DLL reset: pins 0000, `bank` = 0, `addr` = MODE_VALUE with bit 8 set. It comes at least 2 cycles after the extended write.
- R6: No command follows the DLL-reset write for at least LOCK_CYC cycles (200 by default).
- R7: Exactly NUM_REF refresh commands (pins 0001, two by default) are issued. Any command that follows a refresh comes at least the refresh-cycle count later (9 cycles by default).
- R8: The final mode write has pins 0000, `bank` = 0 and `addr` = MODE_VALUE with bit 8 clear. With `mrsFirst` = 0 it comes after the refreshes. With `mrsFirst` = 1 it comes directly after the DLL lock wait, and the first refresh follows it by at least 2 cycles.
- R9: With `testEn` = 1, `testWindow` rises no earlier than the test-window count (12500 cycles by default) and stays high until `testDone`, with `pd` low throughout. With `testEn` = 0, `testWindow` never rises.
- R10: `done` rises exactly one cycle after the last command and stays high. Only NOP appears on the bus after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| testEn | input | 1 | Run the test window before initialization (sampled at reset release) |
| testDone | input | 1 | Closes the test window |
| mrsFirst | input | 1 | 1: final mode write before the refreshes (sampled at reset release) |
| csN | output | 1 | Chip select, active low |
| rasN | output | 1 | Row strobe, active low |
| casN | output | 1 | Column strobe, active low |
| weN | output | 1 | Write enable, active low |
| bank | output | BANK_W | Bank address / mode register select |
| addr | output | ADDR_W | Address / mode payload |
| pd | output | 1 | Power-down pin level (high = active) |
| testWindow | output | 1 | Test window open |
| done | output | 1 | Initialization complete |

## Verification
The hardest case to reach from the ports is the path through the test window. There, the stable-clock wait must be counted from the `testDone` pulse and not from reset, and `pd` must stay low the whole time. The bench gets there by releasing reset with `testEn` high and watching for `testWindow` to rise. It then drives `testDone` a fixed number of cycles later and measures the `pd` rise against that cycle. Both command orders are run end to end, and the bench checks each command's gap from the one before it against its own minimum.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;

  typedef enum logic [2:0] {
    CMD_NOP, CMD_PRE_ALL, CMD_EMRS, CMD_MRS_RST, CMD_MRS_FIN, CMD_REF
  } cmdKind_e;

  typedef enum logic [2:0] {
    DLY_SHORT, DLY_RP, DLY_MRD, DLY_LOCK, DLY_RFC, DLY_STABLE, DLY_TEST
  } dly_e;

  typedef enum logic [3:0] {
    S_IDLE, S_TEST_WAIT, S_TEST_OPEN, S_STABLE_WAIT, S_NOP, S_PRE,
    S_EMRS, S_MRS_RST, S_MRS_FIN, S_REF, S_GAP, S_DONE
  } state_e;

  typedef struct packed {
    logic     issue;
    cmdKind_e cmd;
    logic     load;
    dly_e     dly;
    logic     pdHigh;
    logic     testOpen;
    logic     doneSet;
  } strobe_t;

  // {csN, rasN, casN, weN}
  localparam logic [3:0] PINS_NOP = 4'b0111;
  localparam logic [3:0] PINS_PRE = 4'b0010;
  localparam logic [3:0] PINS_MRS = 4'b0000;
  localparam logic [3:0] PINS_REF = 4'b0001;

  function automatic int ceilDiv(int num, int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int atLeast2(int v);
    return (v < 2) ? 2 : v;
  endfunction

endpackage

// File: rtl/ddr_init_ctrl.sv
module ddr_init_ctrl
  import ddr_init_pkg::*;
#(
  parameter int NUM_REF = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    testEn,
  input  logic    testDone,
  input  logic    mrsFirst,
  input  logic    cntLow,
  output strobe_t stb
);

  localparam int REF_W = $clog2(NUM_REF + 1);

  state_e           state, stateNext;
  state_e           retState, retNext;
  logic             mrsFirstQ;
  logic [REF_W-1:0] refCnt;
  logic             lastRef;

  assign lastRef = (refCnt == REF_W'(NUM_REF - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= S_IDLE;
      retState  <= S_IDLE;
      mrsFirstQ <= 1'b0;
      refCnt    <= '0;
    end else begin
      state    <= stateNext;
      retState <= retNext;
      if (state == S_IDLE) mrsFirstQ <= mrsFirst;
      if (state == S_REF)  refCnt    <= refCnt + 1'b1;
    end
  end

  always_comb begin
    stb       = '0;
    stb.cmd   = CMD_NOP;
    stb.dly   = DLY_SHORT;
    stateNext = state;
    retNext   = retState;
    unique case (state)
      S_IDLE: begin
        stb.load = 1'b1;
        if (testEn) begin
          stb.dly   = DLY_TEST;
          stateNext = S_TEST_WAIT;
        end else begin
          stb.dly   = DLY_STABLE;
          stateNext = S_STABLE_WAIT;
        end
      end
      S_TEST_WAIT: if (cntLow) stateNext = S_TEST_OPEN;
      S_TEST_OPEN: begin
        stb.testOpen = 1'b1;
        if (testDone) begin
          stb.load  = 1'b1;
          stb.dly   = DLY_STABLE;
          stateNext = S_STABLE_WAIT;
        end
      end
      S_STABLE_WAIT: if (cntLow) stateNext = S_NOP;
      S_NOP: begin
        stb.issue  = 1'b1;
        stb.cmd    = CMD_NOP;
        stb.pdHigh = 1'b1;
        stb.load   = 1'b1;
        stb.dly    = DLY_SHORT;
        retNext    = S_PRE;
        stateNext  = S_GAP;
      end
      S_PRE: begin
        stb.issue = 1'b1;
        stb.cmd   = CMD_PRE_ALL;
        stb.load  = 1'b1;
        stb.dly   = DLY_RP;
        retNext   = S_EMRS;
        stateNext = S_GAP;
      end
      S_EMRS: begin
        stb.issue = 1'b1;
        stb.cmd   = CMD_EMRS;
        stb.load  = 1'b1;
        stb.dly   = DLY_MRD;
        retNext   = S_MRS_RST;
        stateNext = S_GAP;
      end
      S_MRS_RST: begin
        stb.issue = 1'b1;
        stb.cmd   = CMD_MRS_RST;
        stb.load  = 1'b1;
        stb.dly   = DLY_LOCK;
        retNext   = mrsFirstQ ? S_MRS_FIN : S_REF;
        stateNext = S_GAP;
      end
      S_MRS_FIN: begin
        stb.issue = 1'b1;
        stb.cmd   = CMD_MRS_FIN;
        if (mrsFirstQ) begin
          stb.load  = 1'b1;
          stb.dly   = DLY_MRD;
          retNext   = S_REF;
          stateNext = S_GAP;
        end else begin
          stateNext = S_DONE;
        end
      end
      S_REF: begin
        stb.issue = 1'b1;
        stb.cmd   = CMD_REF;
        if (lastRef && mrsFirstQ) begin
          stateNext = S_DONE;
        end else begin
          stb.load  = 1'b1;
          stb.dly   = DLY_RFC;
          retNext   = lastRef ? S_MRS_FIN : S_REF;
          stateNext = S_GAP;
        end
      end
      S_GAP:  if (cntLow) stateNext = retState;
      S_DONE: stb.doneSet = 1'b1;
      default: stateNext = S_IDLE;
    endcase
  end

endmodule

// File: rtl/ddr_init_dpath.sv
module ddr_init_dpath
  import ddr_init_pkg::*;
#(
  parameter int ADDR_W       = 11,
  parameter int BANK_W       = 3,
  parameter int CNT_W        = 16,
  parameter int C_SHORT      = 2,
  parameter int C_RP         = 2,
  parameter int C_MRD        = 2,
  parameter int C_LOCK       = 200,
  parameter int C_RFC        = 9,
  parameter int C_STABLE     = 25000,
  parameter int C_TEST       = 12500,
  parameter logic [ADDR_W-1:0] MODE_VALUE = '0,
  parameter logic [ADDR_W-1:0] EXT_VALUE  = '0,
  parameter int DLL_RST_BIT  = 8,
  parameter int DLL_DIS_BIT  = 0,
  parameter int ALL_BANK_BIT = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  output logic              cntLow,
  output logic              csN,
  output logic              rasN,
  output logic              casN,
  output logic              weN,
  output logic [BANK_W-1:0] bank,
  output logic [ADDR_W-1:0] addr,
  output logic              pd,
  output logic              testWindow,
  output logic              done
);

  logic [CNT_W-1:0]  cnt;
  int                loadVal;
  logic [3:0]        pinsNext, pinsQ;
  logic [BANK_W-1:0] bankNext;
  logic [ADDR_W-1:0] addrNext;

  always_comb begin
    unique case (stb.dly)
      DLY_RP:     loadVal = C_RP;
      DLY_MRD:    loadVal = C_MRD;
      DLY_LOCK:   loadVal = C_LOCK;
      DLY_RFC:    loadVal = C_RFC;
      DLY_STABLE: loadVal = C_STABLE;
      DLY_TEST:   loadVal = C_TEST;
      default:    loadVal = C_SHORT;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 cnt <= '0;
    else if (stb.load)         cnt <= CNT_W'(loadVal - 1);
    else if (cnt != '0)        cnt <= cnt - 1'b1;
  end

  assign cntLow = (cnt <= CNT_W'(1));

  always_comb begin
    pinsNext = PINS_NOP;
    bankNext = '0;
    addrNext = '0;
    if (stb.issue) begin
      unique case (stb.cmd)
        CMD_PRE_ALL: begin
          pinsNext               = PINS_PRE;
          addrNext[ALL_BANK_BIT] = 1'b1;
        end
        CMD_EMRS: begin
          pinsNext              = PINS_MRS;
          bankNext              = BANK_W'(1);
          addrNext              = EXT_VALUE;
          addrNext[DLL_DIS_BIT] = 1'b0;
        end
        CMD_MRS_RST: begin
          pinsNext              = PINS_MRS;
          addrNext              = MODE_VALUE;
          addrNext[DLL_RST_BIT] = 1'b1;
        end
        CMD_MRS_FIN: begin
          pinsNext              = PINS_MRS;
          addrNext              = MODE_VALUE;
          addrNext[DLL_RST_BIT] = 1'b0;
        end
        CMD_REF: pinsNext = PINS_REF;
        default: pinsNext = PINS_NOP;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pinsQ      <= PINS_NOP;
      bank       <= '0;
      addr       <= '0;
      pd         <= 1'b0;
      testWindow <= 1'b0;
      done       <= 1'b0;
    end else begin
      pinsQ      <= pinsNext;
      bank       <= bankNext;
      addr       <= addrNext;
      testWindow <= stb.testOpen;
      if (stb.pdHigh)  pd   <= 1'b1;
      if (stb.doneSet) done <= 1'b1;
    end
  end

  assign {csN, rasN, casN, weN} = pinsQ;

endmodule

// File: rtl/ddr_init_seq.sv
module ddr_init_seq
  import ddr_init_pkg::*;
#(
  parameter int ADDR_W        = 11,
  parameter int BANK_W        = 3,
  parameter int CLK_PERIOD_PS = 8000,
  parameter int STABLE_PS     = 200_000_000,
  parameter int TEST_PS       = 100_000_000,
  parameter int TRP_PS        = 15_000,
  parameter int TRFC_PS       = 70_000,
  parameter int TMRD_CYC      = 2,
  parameter int LOCK_CYC      = 200,
  parameter int NUM_REF       = 2,
  parameter logic [ADDR_W-1:0] MODE_VALUE = 11'h032,
  parameter logic [ADDR_W-1:0] EXT_VALUE  = 11'h002,
  parameter int DLL_RST_BIT   = 8,
  parameter int DLL_DIS_BIT   = 0,
  parameter int ALL_BANK_BIT  = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              testEn,
  input  logic              testDone,
  input  logic              mrsFirst,
  output logic              csN,
  output logic              rasN,
  output logic              casN,
  output logic              weN,
  output logic [BANK_W-1:0] bank,
  output logic [ADDR_W-1:0] addr,
  output logic              pd,
  output logic              testWindow,
  output logic              done
);

  localparam int C_STABLE = atLeast2(ceilDiv(STABLE_PS, CLK_PERIOD_PS));
  localparam int C_TEST   = atLeast2(ceilDiv(TEST_PS, CLK_PERIOD_PS));
  localparam int C_RP     = atLeast2(ceilDiv(TRP_PS, CLK_PERIOD_PS));
  localparam int C_RFC    = atLeast2(ceilDiv(TRFC_PS, CLK_PERIOD_PS));
  localparam int C_MRD    = atLeast2(TMRD_CYC);
  localparam int C_LOCK   = atLeast2(LOCK_CYC);
  localparam int CNT_W    = $clog2(C_STABLE + C_TEST + C_LOCK + C_RFC + 1) + 1;

  strobe_t stb;
  logic    cntLow;

  ddr_init_ctrl #(.NUM_REF(NUM_REF)) u_ctrl (
    .clk(clk), .rstN(rstN), .testEn(testEn), .testDone(testDone),
    .mrsFirst(mrsFirst), .cntLow(cntLow), .stb(stb)
  );

  ddr_init_dpath #(
    .ADDR_W(ADDR_W), .BANK_W(BANK_W), .CNT_W(CNT_W),
    .C_SHORT(2), .C_RP(C_RP), .C_MRD(C_MRD), .C_LOCK(C_LOCK), .C_RFC(C_RFC),
    .C_STABLE(C_STABLE), .C_TEST(C_TEST),
    .MODE_VALUE(MODE_VALUE), .EXT_VALUE(EXT_VALUE),
    .DLL_RST_BIT(DLL_RST_BIT), .DLL_DIS_BIT(DLL_DIS_BIT), .ALL_BANK_BIT(ALL_BANK_BIT)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .cntLow(cntLow),
    .csN(csN), .rasN(rasN), .casN(casN), .weN(weN),
    .bank(bank), .addr(addr), .pd(pd), .testWindow(testWindow), .done(done)
  );

endmodule

// File: rtl/ddr_init_chk.sv
module ddr_init_chk
  import ddr_init_pkg::*;
#(
  parameter int ADDR_W       = 11,
  parameter int BANK_W       = 3,
  parameter int DLL_DIS_BIT  = 0,
  parameter int ALL_BANK_BIT = 10
) (
  input logic              clk,
  input logic              rstN,
  input logic              csN,
  input logic              rasN,
  input logic              casN,
  input logic              weN,
  input logic [BANK_W-1:0] bank,
  input logic [ADDR_W-1:0] addr,
  input logic              pd,
  input logic              testWindow,
  input logic              done
);

  logic [3:0] pins;
  assign pins = {csN, rasN, casN, weN};

  assert_quiet_while_pd_low_R2: assert property (@(posedge clk) disable iff (!rstN)
    !pd |-> pins == PINS_NOP);

  assert_pd_sticky_R2: assert property (@(posedge clk) disable iff (!rstN)
    pd |=> pd);

  assert_nop_on_pd_rise_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pd) |-> pins == PINS_NOP);

  assert_precharge_all_R3: assert property (@(posedge clk) disable iff (!rstN)
    pins == PINS_PRE |-> addr[ALL_BANK_BIT]);

  assert_ext_dll_on_R4: assert property (@(posedge clk) disable iff (!rstN)
    (pins == PINS_MRS && bank == BANK_W'(1)) |-> !addr[DLL_DIS_BIT]);

  assert_test_pd_low_R9: assert property (@(posedge clk) disable iff (!rstN)
    testWindow |-> !pd);

  assert_done_sticky_R10: assert property (@(posedge clk) disable iff (!rstN)
    done |=> done);

  assert_done_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (pins == PINS_NOP && pd));

endmodule

bind ddr_init_seq ddr_init_chk #(
  .ADDR_W(ADDR_W), .BANK_W(BANK_W), .DLL_DIS_BIT(DLL_DIS_BIT), .ALL_BANK_BIT(ALL_BANK_BIT)
) u_chk (
  .clk(clk), .rstN(rstN), .csN(csN), .rasN(rasN), .casN(casN), .weN(weN),
  .bank(bank), .addr(addr), .pd(pd), .testWindow(testWindow), .done(done)
);

// File: tb/ddr_init_seq_test.sv
module ddr_init_seq_test;

  localparam int PERIOD_PS = 8000;
  localparam int T_STABLE  = (200_000_000 + PERIOD_PS - 1) / PERIOD_PS;
  localparam int T_TEST    = (100_000_000 + PERIOD_PS - 1) / PERIOD_PS;
  localparam int T_RP      = (15_000 + PERIOD_PS - 1) / PERIOD_PS;
  localparam int T_RFC     = (70_000 + PERIOD_PS - 1) / PERIOD_PS;
  localparam int T_MRD     = 2;
  localparam int T_LOCK    = 200;
  localparam logic [10:0] MODE_V = 11'h032;
  localparam logic [10:0] EXT_V  = 11'h002;
  localparam logic [3:0] P_NOP = 4'b0111, P_PRE = 4'b0010, P_MRS = 4'b0000, P_REF = 4'b0001;

  logic clk = 1'b0;
  logic rstN = 1'b0, testEn = 1'b0, testDone = 1'b0, mrsFirst = 1'b0;
  logic csN, rasN, casN, weN, pd, testWindow, done;
  logic [2:0]  bank;
  logic [10:0] addr;

  int vectors = 0;
  int misses  = 0;
  int globalCyc = 0;

  always #4 clk = ~clk;
  always @(posedge clk) globalCyc++;

  ddr_init_seq uut (
    .clk(clk), .rstN(rstN), .testEn(testEn), .testDone(testDone), .mrsFirst(mrsFirst),
    .csN(csN), .rasN(rasN), .casN(casN), .weN(weN), .bank(bank), .addr(addr),
    .pd(pd), .testWindow(testWindow), .done(done)
  );

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    vectors++;
    if (!ok) begin
      misses++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // one full initialization run; each scenario checks its own log
  task automatic runSeq(input bit tEn, input bit mFirst);
    int cyc = 0, pdRise = -1, twRise = -1, tdCyc = -1, doneCyc = -1, n = 0;
    int quietBad = 0, riseBad = 0, pdFell = 0, twBad = 0, postBad = 0, doneDrop = 0;
    logic [3:0]  lp [8];
    logic [2:0]  lb [8];
    logic [10:0] la [8];
    int          lc [8];
    logic [3:0]  ep [6];
    logic [2:0]  eb [6];
    logic [10:0] ea [6];
    int          eg [6];
    logic [3:0]  pins;

    rstN = 1'b0; testDone = 1'b0; testEn = tEn; mrsFirst = mFirst;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check({csN,rasN,casN,weN} == P_NOP && !pd && !done && !testWindow, "R1",
          "reset state (pins)", int'({csN,rasN,casN,weN}), int'(P_NOP));
    rstN = 1'b1;
    for (int i = 0; i < 60000; i++) begin
      @(negedge clk);
      cyc++;
      pins = {csN, rasN, casN, weN};
      if (cyc == 1)
        check(pins == P_NOP && !pd && !done && !testWindow, "R1", "first cycle after reset", int'(pd), 0);
      if (pdRise < 0) begin
        if (pd) begin
          pdRise = cyc;
          if (pins != P_NOP) riseBad++;
        end else if (pins != P_NOP) quietBad++;
      end else if (!pd) pdFell++;
      if (testWindow && twRise < 0) twRise = cyc;
      if (testWindow && (!tEn || pd)) twBad++;
      if (testDone && cyc == tdCyc + 1) testDone = 1'b0;
      if (tEn && twRise >= 0 && tdCyc < 0 && cyc == twRise + 40) begin
        testDone = 1'b1;
        tdCyc = cyc;
      end
      if (doneCyc >= 0) begin
        if (pins != P_NOP) postBad++;
        if (!done) doneDrop++;
      end else if (pd && pins != P_NOP) begin
        if (n < 8) begin lp[n] = pins; lb[n] = bank; la[n] = addr; lc[n] = cyc; end
        n++;
      end
      if (done && doneCyc < 0) doneCyc = cyc;
      if (doneCyc >= 0 && cyc > doneCyc + 30) break;
    end

    // expected command list
    ep[0] = P_PRE; eb[0] = 3'd0; ea[0] = 11'h400; eg[0] = 1;
    ep[1] = P_MRS; eb[1] = 3'd1; ea[1] = EXT_V & ~11'h001; eg[1] = T_RP;
    ep[2] = P_MRS; eb[2] = 3'd0; ea[2] = MODE_V | 11'h100; eg[2] = T_MRD;
    if (!mFirst) begin
      ep[3] = P_REF; eb[3] = 3'd0; ea[3] = 11'h000; eg[3] = T_LOCK;
      ep[4] = P_REF; eb[4] = 3'd0; ea[4] = 11'h000; eg[4] = T_RFC;
      ep[5] = P_MRS; eb[5] = 3'd0; ea[5] = MODE_V & ~11'h100; eg[5] = T_RFC;
    end else begin
      ep[3] = P_MRS; eb[3] = 3'd0; ea[3] = MODE_V & ~11'h100; eg[3] = T_LOCK;
      ep[4] = P_REF; eb[4] = 3'd0; ea[4] = 11'h000; eg[4] = T_MRD;
      ep[5] = P_REF; eb[5] = 3'd0; ea[5] = 11'h000; eg[5] = T_RFC;
    end

    check(quietBad == 0, "R2", "commands while pd low", quietBad, 0);
    check(pdRise > 0 && riseBad == 0, "R2", "NOP at pd rise", riseBad, 0);
    check(pdRise - (tEn ? tdCyc : 0) >= T_STABLE, "R2", "stable wait cycles",
          pdRise - (tEn ? tdCyc : 0), T_STABLE);
    check(pdFell == 0, "R2", "pd fell after rise", pdFell, 0);
    if (tEn) begin
      check(twRise >= T_TEST, "R9", "test window open cycle", twRise, T_TEST);
      check(tdCyc > 0, "R9", "test window reached", tdCyc, twRise + 40);
    end
    check(twBad == 0, "R9", "test window misuse", twBad, 0);
    check(n == 6, "R7", "command count (two refreshes)", n, 6);
    if (n == 6) begin
      check(lp[0] == ep[0] && la[0][10], "R3", "close-all command", int'(lp[0]), int'(ep[0]));
      check(lc[0] - pdRise >= eg[0], "R3", "close-all after NOP", lc[0] - pdRise, eg[0]);
      check(lp[1] == ep[1] && lb[1] == eb[1] && la[1] == ea[1], "R4", "extended mode write payload",
            int'(la[1]), int'(ea[1]));
      check(lc[1] - lc[0] >= eg[1], "R4", "gap after close-all", lc[1] - lc[0], eg[1]);
      check(lp[2] == ep[2] && lb[2] == eb[2] && la[2] == ea[2], "R5", "DLL reset mode write payload",
            int'(la[2]), int'(ea[2]));
      check(lc[2] - lc[1] >= eg[2], "R5", "gap after extended write", lc[2] - lc[1], eg[2]);
      check(lc[3] - lc[2] >= eg[3], "R6", "DLL lock wait", lc[3] - lc[2], eg[3]);
      for (int k = 3; k < 6; k++) begin
        if (ep[k] == P_REF)
          check(lp[k] == P_REF, "R7", $sformatf("refresh at slot %0d", k), int'(lp[k]), int'(P_REF));
        else
          check(lp[k] == ep[k] && lb[k] == eb[k] && la[k] == ea[k], "R8",
                $sformatf("final mode write at slot %0d", k), int'(la[k]), int'(ea[k]));
      end
      for (int k = 4; k < 6; k++)
        check(lc[k] - lc[k-1] >= eg[k], ep[k-1] == P_REF ? "R7" : "R8",
              $sformatf("gap before slot %0d", k), lc[k] - lc[k-1], eg[k]);
      check(doneCyc == lc[5] + 1, "R10", "done timing", doneCyc, lc[5] + 1);
    end
    check(postBad == 0 && doneCyc > 0, "R10", "commands after done", postBad, 0);
    check(doneDrop == 0, "R10", "done dropped", doneDrop, 0);
  endtask

  task automatic testPlainOrder();
    runSeq(1'b0, 1'b0);
  endtask

  task automatic testModeFirstOrder();
    runSeq(1'b0, 1'b1);
  endtask

  task automatic testWithWindow();
    runSeq(1'b1, 1'b0);
  endtask

  initial begin
    testPlainOrder();
    testModeFirstOrder();
    testWithWindow();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    wait (globalCyc >= 190000);
    vectors++;
    misses++;
    $display("FAIL watchdog: actual %0d cycles expected completion", globalCyc);
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule